// File: doc/BRIEF.md
# Double-Banked 8x8 Block Transposer

This block connects two serial one-dimensional transform stages. The first stage delivers an 8x8 block of 12-bit values one element per cycle, in row-major order. The block returns each 8x8 block in column-major order, one element per cycle, so the second stage can work down the columns.

Storage is two banks of 64 words. One bank is filled while the other is drained, and the two swap roles when a whole block has been written and the earlier block has been read out. The data is never moved inside a bank. The transpose comes only from the order of the addresses: the write address is row*8+col, and the read address walks through the same locations with the row index running fastest.

Because the reader runs as fast as the writer and the output has no backpressure, blocks can stream back to back without a stall. The write-side ready signal drops only if the bank the writer needs next is still waiting to be read.

Top module: `transpose_pingpong`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Output element k of a block (k = 0..63) equals input element (k mod 8)*8 + (k div 8) of the same block. The input index is row*8+col, counted in the order the elements were accepted.
- R3: Once a block starts on the output, its 64 elements appear with `out_valid` high on 64 consecutive cycles.
- R4: `out_sob` is 1 on the first output element of each block and 0 on the other 63 elements.
- R5: The first element of a block is valid at the output on the second rising edge after the edge that accepts the block's 64th input element.
- R6: No output is valid until 64 elements have been accepted. A partly written block produces no output, however long the input stays idle.
- R7: A cycle with `in_valid` low writes nothing and does not advance the write position. Gaps inside a block do not change its contents or their order.
- R8: When blocks are written back to back with no idle cycles, `in_ready` stays 1 throughout.
- R9: Blocks written back to back come out back to back. The first element of each block follows the last element of the previous block on the next cycle.
- R10: Blocks leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element present |
| in_data | input | 12 | Input element, row-major order |
| in_ready | output | 1 | Element is accepted on the edge where in_valid and in_ready are both 1 |
| out_valid | output | 1 | Output element present |
| out_sob | output | 1 | Marks the first output element of a block |
| out_data | output | 12 | Output element, column-major order |

## Verification
The bench first writes 40 elements of a block and then idles for a long time. A design that starts reading a bank before the bank is full would emit data during the idle, and this test catches it.

Every output element is compared against the index-swapped input. A read address with the row and column fields the wrong way round would return the block untransposed.

Four blocks are streamed with no idle cycles. A bank swap that waits one cycle too long would drop `in_ready` or open a gap between blocks, and a swap that happens too early would mix blocks or reorder them.

A final block is written with an idle cycle after every element. A write counter that also advanced on idle cycles would scramble the addresses.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    function automatic bank_e other_bank(bank_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction

endpackage

// File: rtl/tp_bank_ram.sv
module tp_bank_ram #(
    parameter int DATA_W = 12,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 2 ** AW;

    logic [DATA_W-1:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem_q[raddr];
        end
    end
endmodule

// File: rtl/tp_ctrl.sv
module tp_ctrl
    import tp_pkg::*;
#(
    parameter int LOG_DIM = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    output logic [1:0]             bank_we,
    output logic [2*LOG_DIM-1:0]   wr_addr,
    output logic [1:0]             bank_re,
    output logic [2*LOG_DIM-1:0]   rd_addr,
    output logic                   out_valid,
    output logic                   out_sob,
    output bank_e                  out_bank
);
    localparam int AW = 2 * LOG_DIM;
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    typedef struct packed {
        logic [AW-1:0] wr_cnt;
        logic [AW-1:0] rd_cnt;
        bank_e         wr_bank;
        bank_e         rd_bank;
        logic [1:0]    full;
        logic          out_valid;
        logic          out_sob;
        bank_e         out_bank;
    } state_t;

    state_t s_d, s_q;
    logic   wr_fire, rd_fire;

    always_comb begin
        s_d     = s_q;
        wr_fire = in_valid && !s_q.full[s_q.wr_bank];
        rd_fire = s_q.full[s_q.rd_bank];

        if (wr_fire) begin
            s_d.wr_cnt = s_q.wr_cnt + 1'b1;
            if (s_q.wr_cnt == LAST) begin
                s_d.full[s_q.wr_bank] = 1'b1;
                s_d.wr_bank           = other_bank(s_q.wr_bank);
            end
        end

        if (rd_fire) begin
            s_d.rd_cnt = s_q.rd_cnt + 1'b1;
            if (s_q.rd_cnt == LAST) begin
                s_d.full[s_q.rd_bank] = 1'b0;
                s_d.rd_bank           = other_bank(s_q.rd_bank);
            end
        end

        s_d.out_valid = rd_fire;
        s_d.out_sob   = rd_fire && (s_q.rd_cnt == '0);
        s_d.out_bank  = s_q.rd_bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{wr_cnt: '0, rd_cnt: '0, wr_bank: BANK_A, rd_bank: BANK_A,
                     full: 2'b00, out_valid: 1'b0, out_sob: 1'b0, out_bank: BANK_A};
        end else begin
            s_q <= s_d;
        end
    end

    // Row-major write: the count is row*DIM+col.
    // Column-major read: the row index is the fast-running low field.
    assign wr_addr = s_q.wr_cnt;
    assign rd_addr = {s_q.rd_cnt[LOG_DIM-1:0], s_q.rd_cnt[AW-1:LOG_DIM]};

    for (genvar g = 0; g < 2; g++) begin : g_sel
        assign bank_we[g] = wr_fire && (s_q.wr_bank == bank_e'(g));
        assign bank_re[g] = rd_fire && (s_q.rd_bank == bank_e'(g));
    end

    assign in_ready  = !s_q.full[s_q.wr_bank];
    assign out_valid = s_q.out_valid;
    assign out_sob   = s_q.out_sob;
    assign out_bank  = s_q.out_bank;
endmodule

// File: rtl/transpose_pingpong.sv
module transpose_pingpong
    import tp_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int LOG_DIM = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic              out_sob,
    output logic [DATA_W-1:0] out_data
);
    localparam int AW = 2 * LOG_DIM;

    logic [1:0]        bank_we, bank_re;
    logic [AW-1:0]     wr_addr, rd_addr;
    bank_e             out_bank;
    logic [DATA_W-1:0] bank_rdata [2];

    tp_ctrl #(.LOG_DIM(LOG_DIM)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .bank_we  (bank_we),
        .wr_addr  (wr_addr),
        .bank_re  (bank_re),
        .rd_addr  (rd_addr),
        .out_valid(out_valid),
        .out_sob  (out_sob),
        .out_bank (out_bank)
    );

    for (genvar g = 0; g < 2; g++) begin : g_bank
        tp_bank_ram #(.DATA_W(DATA_W), .AW(AW)) i_ram (
            .clk  (clk),
            .we   (bank_we[g]),
            .waddr(wr_addr),
            .wdata(in_data),
            .re   (bank_re[g]),
            .raddr(rd_addr),
            .rdata(bank_rdata[g])
        );
    end

    assign out_data = bank_rdata[out_bank];
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
    parameter int LOG_DIM = 3
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic out_sob
);
    localparam int AW    = 2 * LOG_DIM;
    localparam int DEPTH = 2 ** AW;

    logic [AW-1:0] beat_q;
    logic [AW:0]   seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
            seen_q <= '0;
        end else begin
            if (out_valid) beat_q <= beat_q + 1'b1;
            if (in_valid && in_ready && seen_q != (AW+1)'(DEPTH)) seen_q <= seen_q + 1'b1;
        end
    end

    // R4: a block marker appears only with valid data, and only at beat zero
    p_sob_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_sob |-> (out_valid && beat_q == '0));

    // R4: the first beat of every block carries the marker
    p_beat0_marked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && beat_q == '0) |-> out_sob);

    // R3: a started block continues without gaps
    p_no_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && beat_q != '1) |=> out_valid);

    // R6: nothing is emitted before one full block has been accepted
    p_no_early_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seen_q == (AW+1)'(DEPTH)));

    // R8: the writer stalls only while the reader is busy
    p_stall_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid);
endmodule

bind transpose_pingpong tp_checker #(.LOG_DIM(LOG_DIM)) i_tp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_sob  (out_sob)
);

// File: tb/test_transpose_pingpong.sv
module test_transpose_pingpong;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        in_ready, out_valid, out_sob;
    logic [11:0] out_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_acc = 0;
    int ready_low = 0;

    logic [11:0] cap_data [1024];
    logic        cap_sob  [1024];
    int          cap_cyc  [1024];
    int          cap_n = 0;

    transpose_pingpong i_transpose_pingpong (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_sob(out_sob), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 1024) begin
            cap_data[cap_n] = out_data;
            cap_sob[cap_n]  = out_sob;
            cap_cyc[cap_n]  = cyc;
            cap_n = cap_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] elem(input int b, input int i);
        return 12'(((b & 63) << 6) | (i & 63));
    endfunction

    task automatic send_elem(input logic [11:0] v);
        forever begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = v;
            if (in_ready) begin
                last_acc = cyc + 1;
                break;
            end
            ready_low++;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 12'hABC;
        end
    endtask

    // Checks transpose (R2), marker (R4) and contiguity (R3) of one captured block
    task automatic verify_block(input int base, input int b);
        int bad_data = 0, bad_sob = 0, bad_gap = 0;
        int first_act = 0, first_exp = 0;
        check(cap_n >= base + 64, "R3 block fully delivered", cap_n, base + 64);
        if (cap_n < base + 64) return;
        for (int k = 0; k < 64; k++) begin
            logic [11:0] e;
            e = elem(b, (k % 8) * 8 + k / 8);
            if (cap_data[base+k] !== e) begin
                if (bad_data == 0) begin first_act = cap_data[base+k]; first_exp = e; end
                bad_data++;
            end
            if (cap_sob[base+k] !== (k == 0)) bad_sob++;
            if (cap_cyc[base+k] != cap_cyc[base] + k) bad_gap++;
        end
        check(bad_data == 0, "R2/R10 transposed data of block", first_act, first_exp);
        check(bad_sob == 0, "R4 start marker only on element 0", bad_sob, 0);
        check(bad_gap == 0, "R3 64 consecutive valid cycles", bad_gap, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_partial_then_finish;
        for (int i = 0; i < 40; i++) send_elem(elem(0, i));
        idle(100);
        check(cap_n == 0, "R6 no output from partial block", cap_n, 0);
        for (int i = 40; i < 64; i++) send_elem(elem(0, i));
        idle(80);
        check(cap_n == 64, "R6 exactly one block after completion", cap_n, 64);
        check(cap_cyc[0] == last_acc + 1, "R5 first output latency", cap_cyc[0], last_acc + 1);
        verify_block(0, 0);
    endtask

    task automatic t_stream;
        int base = cap_n;
        ready_low = 0;
        for (int b = 1; b <= 4; b++)
            for (int i = 0; i < 64; i++) send_elem(elem(b, i));
        idle(90);
        check(ready_low == 0, "R8 ready held high while streaming", ready_low, 0);
        check(cap_n == base + 256, "R9 four blocks delivered", cap_n, base + 256);
        for (int j = 0; j < 4; j++) verify_block(base + 64 * j, j + 1);
        for (int j = 0; j < 3; j++)
            check(cap_cyc[base + 64*j + 64] == cap_cyc[base + 64*j + 63] + 1,
                  "R9 next block follows without gap",
                  cap_cyc[base + 64*j + 64], cap_cyc[base + 64*j + 63] + 1);
    endtask

    task automatic t_gappy;
        int base = cap_n;
        for (int i = 0; i < 64; i++) begin
            send_elem(elem(5, i));
            idle(1);
        end
        idle(80);
        check(cap_n == base + 64, "R7 gaps add no elements", cap_n, base + 64);
        check(cap_cyc[base] == last_acc + 1, "R5 latency after gapped block", cap_cyc[base], last_acc + 1);
        verify_block(base, 5);
    endtask

    initial begin
        t_reset();
        t_partial_then_finish();
        t_stream();
        t_gappy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule